// File: doc/BRIEF.md
# Multiply-Accumulate Coprocessor

This block sits beside a 16-bit processor. It holds a 32-bit accumulator and works under an 8-bit mode value. The processor first writes the mode over a mode-write strobe. It then issues data commands, each carrying two 16-bit operands: the current value of a destination register and a source value, which may be a register or an immediate. The mode decides what a data command does. It can load the accumulator from the operands, run a signed or unsigned 16x16 multiply with a 32-bit accumulate, or return one half of the accumulator without changing it.

Every data command returns a 16-bit result word and a 4-bit flag nibble ordered C, V, Z, N from the most significant bit down. Both are registered and appear one clock after the command strobe. They hold their values until the next command that executes. Bit 4 of the mode picks which half of the accumulator is returned: clear for bits [15:0], set for bits [31:16]. Writing mode 0x00 zeroes the accumulator at the moment of the write.

Top module: `mac_copro`

## Requirements
- R1: After reset the result word is 0x0000, the flag nibble is 0b0000, the mode register holds 0x00 and the accumulator is zero.
- R2: A mode write of 0x00 sets the accumulator to zero on that clock edge, without any data command.
- R3: In mode 0x01 a data command sets the accumulator to {16'h0000, source} and returns result 0x0000 with flags 0b0000.
- R4: In mode 0x02 a data command sets the accumulator to {destination, source} and returns result 0x0000 with flags 0b0000.
- R5: In modes 0x06 and 0x16 a data command sets the accumulator to (destination x source + accumulator) mod 2^32, with both operands unsigned. The flags are always 0b0000, even when the sum carries out.
- R6: In modes 0x07 and 0x17 the operands are two's-complement. If the product and the old accumulator have the same sign and the 32-bit sum has the other sign, the flags are 0b0100 (V, bit 2) and the accumulator keeps the wrapped sum. Otherwise the flags are 0b0000.
- R7: After a multiply-accumulate, the result word is bits [15:0] of the new accumulator in modes 0x06/0x07 and bits [31:16] in modes 0x16/0x17.
- R8: In mode 0x13 a data command returns accumulator bits [31:16], and in mode 0x03 it returns bits [15:0]. Flags are 0b0000 and the accumulator is unchanged.
- R9: A data command in mode 0x00 or in any mode not listed above leaves the accumulator unchanged and returns result 0x0000 with flags 0b0000.
- R10: Result and flags change only on the clock edge that takes a data command. They are valid one clock later and hold while no command arrives.
- R11: When a mode write and a data command arrive on the same edge, the mode write takes effect and the data command is dropped. The result, the flags and the accumulator (unless the new mode is 0x00) stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Mode-write strobe |
| mode_wdata | input | 8 | Mode value to write |
| cmd_valid | input | 1 | Data-command strobe |
| op_dst | input | 16 | Destination-register operand |
| op_src | input | 16 | Source operand (register or immediate) |
| res_out | output | 16 | Registered result word |
| flags_out | output | 4 | Registered flags {C, V, Z, N} |

## Verification
The bench drives signed overflow in both directions: a positive sum wrapping to 0x80000000 and a negative sum wrapping to 0x7FFFFFFF. A design that tested only the sum's sign, or compared the wrong addends, would set V on the wrong command or miss one of the cases. It repeats the same all-ones operands in the unsigned and the signed high-half modes, where a shared or wrongly extended multiplier returns 0xFFFE in both instead of 0xFFFE and 0x0000. It also adds an unsigned sum that carries out of 32 bits, which a design that raised V without regard to signedness would flag. Further stimulus covers a dropped command under a simultaneous mode write, commands in unsupported modes issued after the outputs are already nonzero, and idle cycles after an overflow. These catch a design that lets the command win, that leaves stale output, or that lets the flags decay.

// File: rtl/mac_copro_pkg.sv
package mac_copro_pkg;

   localparam int MODE_W   = 8;
   localparam int HALF_BIT = 4;

   localparam logic [MODE_W-1:0] MD_CLEAR     = 8'h00;
   localparam logic [MODE_W-1:0] MD_LOAD_LO   = 8'h01;
   localparam logic [MODE_W-1:0] MD_LOAD_FULL = 8'h02;
   localparam logic [MODE_W-1:0] MD_READ_LO   = 8'h03;
   localparam logic [MODE_W-1:0] MD_READ_HI   = 8'h13;
   localparam logic [MODE_W-1:0] MD_MAC_U_LO  = 8'h06;
   localparam logic [MODE_W-1:0] MD_MAC_S_LO  = 8'h07;
   localparam logic [MODE_W-1:0] MD_MAC_U_HI  = 8'h16;
   localparam logic [MODE_W-1:0] MD_MAC_S_HI  = 8'h17;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_LOAD_LO,
      OP_LOAD_FULL,
      OP_READ,
      OP_MAC
   } op_e;

   typedef struct packed {
      logic c;
      logic v;
      logic z;
      logic n;
   } flags_t;

   typedef struct packed {
      op_e  op;
      logic is_signed;
      logic hi_half;
   } dec_t;

endpackage

// File: rtl/mac_mode_ctl.sv
module mac_mode_ctl
   import mac_copro_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   output logic [MODE_W-1:0] mode_q,
   output dec_t              dec
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= MD_CLEAR;
      else if (mode_we) mode_q <= mode_wdata;
   end

   always_comb begin
      dec.op        = OP_NONE;
      dec.is_signed = 1'b0;
      dec.hi_half   = mode_q[HALF_BIT];
      case (mode_q)
         MD_LOAD_LO:                dec.op = OP_LOAD_LO;
         MD_LOAD_FULL:              dec.op = OP_LOAD_FULL;
         MD_READ_LO, MD_READ_HI:    dec.op = OP_READ;
         MD_MAC_U_LO, MD_MAC_U_HI:  dec.op = OP_MAC;
         MD_MAC_S_LO, MD_MAC_S_HI: begin
            dec.op        = OP_MAC;
            dec.is_signed = 1'b1;
         end
         default:                   dec.op = OP_NONE;
      endcase
   end

endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
   parameter int DW        = 16,
   parameter int MUL_STYLE = 0,
   localparam int AW       = 2 * DW
) (
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic [AW-1:0] acc,
   input  logic          is_signed,
   output logic [AW-1:0] sum,
   output logic          ovf
);

   logic [AW-1:0] a_ext;
   logic [AW-1:0] b_ext;
   logic [AW-1:0] prod;

   assign a_ext = {{DW{is_signed & op_a[DW-1]}}, op_a};
   assign b_ext = {{DW{is_signed & op_b[DW-1]}}, op_b};

   if (MUL_STYLE == 0) begin : g_mul_op
      assign prod = a_ext * b_ext;
   end else begin : g_mul_shift_add
      logic [AW-1:0] part [AW+1];
      assign part[0] = '0;
      for (genvar i = 0; i < AW; i++) begin : g_row
         assign part[i+1] = part[i] + (b_ext[i] ? (a_ext << i) : '0);
      end
      assign prod = part[AW];
   end

   assign sum = prod + acc;
   assign ovf = is_signed & (prod[AW-1] == acc[AW-1]) & (sum[AW-1] != prod[AW-1]);

endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg
   import mac_copro_pkg::*;
#(
   parameter int DW  = 16,
   localparam int AW = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          exec,
   input  dec_t          dec,
   input  logic [DW-1:0] op_dst,
   input  logic [DW-1:0] op_src,
   input  logic [AW-1:0] mac_sum,
   input  logic          mac_ovf,
   output logic [AW-1:0] acc_q,
   output logic [DW-1:0] out_q,
   output flags_t        flg_q
);

   logic [AW-1:0] acc_n;
   logic [DW-1:0] out_n;
   flags_t        flg_n;

   function automatic logic [DW-1:0] pick_half(input logic [AW-1:0] v, input logic hi);
      return hi ? v[AW-1:DW] : v[DW-1:0];
   endfunction

   always_comb begin
      acc_n = acc_q;
      out_n = out_q;
      flg_n = flg_q;
      if (clr) begin
         acc_n = '0;
      end else if (exec) begin
         out_n = '0;
         flg_n = '0;
         case (dec.op)
            OP_LOAD_LO:   acc_n = {{DW{1'b0}}, op_src};
            OP_LOAD_FULL: acc_n = {op_dst, op_src};
            OP_READ:      out_n = pick_half(acc_q, dec.hi_half);
            OP_MAC: begin
               acc_n   = mac_sum;
               out_n   = pick_half(mac_sum, dec.hi_half);
               flg_n.v = mac_ovf;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         out_q <= '0;
         flg_q <= '0;
      end else begin
         acc_q <= acc_n;
         out_q <= out_n;
         flg_q <= flg_n;
      end
   end

endmodule

// File: rtl/mac_copro.sv
module mac_copro
   import mac_copro_pkg::*;
#(
   parameter int DW        = 16,
   parameter int MUL_STYLE = 0,
   localparam int AW       = 2 * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              cmd_valid,
   input  logic [DW-1:0]     op_dst,
   input  logic [DW-1:0]     op_src,
   output logic [DW-1:0]     res_out,
   output logic [3:0]        flags_out
);

   if (DW < 2) begin : g_bad_dw
      $error("mac_copro: DW must be at least 2");
   end
   if (DW <= HALF_BIT) begin : g_bad_half
      $error("mac_copro: DW too small for the mode layout");
   end
   if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
      $error("mac_copro: MUL_STYLE must be 0 or 1");
   end

   logic [MODE_W-1:0] mode_q;
   dec_t              dec;
   logic [AW-1:0]     acc_q;
   logic [AW-1:0]     mac_sum;
   logic              mac_ovf;
   flags_t            flg_q;
   logic              clr;
   logic              exec;

   assign clr  = mode_we && (mode_wdata == MD_CLEAR);
   assign exec = cmd_valid && !mode_we;

   mac_mode_ctl u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_we    (mode_we),
      .mode_wdata (mode_wdata),
      .mode_q     (mode_q),
      .dec        (dec)
   );

   mac_arith #(.DW(DW), .MUL_STYLE(MUL_STYLE)) u_arith (
      .op_a      (op_dst),
      .op_b      (op_src),
      .acc       (acc_q),
      .is_signed (dec.is_signed),
      .sum       (mac_sum),
      .ovf       (mac_ovf)
   );

   mac_acc_reg #(.DW(DW)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .exec    (exec),
      .dec     (dec),
      .op_dst  (op_dst),
      .op_src  (op_src),
      .mac_sum (mac_sum),
      .mac_ovf (mac_ovf),
      .acc_q   (acc_q),
      .out_q   (res_out),
      .flg_q   (flg_q)
   );

   assign flags_out = flg_q;

endmodule

// File: rtl/mac_copro_chk.sv
module mac_copro_chk #(
   parameter int DW  = 16,
   localparam int AW = 2 * DW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_we,
   input logic [7:0]    mode_wdata,
   input logic          cmd_valid,
   input logic [DW-1:0] op_dst,
   input logic [DW-1:0] op_src,
   input logic [DW-1:0] res_out,
   input logic [3:0]    flags_out,
   input logic [7:0]    mode_q,
   input logic [AW-1:0] acc_q
);

   logic run;
   logic known;
   assign run   = cmd_valid && !mode_we;
   assign known = (mode_q == 8'h01) || (mode_q == 8'h02) || (mode_q == 8'h03) ||
                  (mode_q == 8'h13) || (mode_q == 8'h06) || (mode_q == 8'h07) ||
                  (mode_q == 8'h16) || (mode_q == 8'h17);

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_we && mode_wdata == 8'h00) |=> (acc_q == '0));

   p_load_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode_q == 8'h01) |=> (acc_q == {{DW{1'b0}}, $past(op_src)} && res_out == '0));

   p_load_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode_q == 8'h02) |=> (acc_q == {$past(op_dst), $past(op_src)}));

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (mode_q == 8'h06 || mode_q == 8'h16)) |=> (flags_out == 4'b0000));

   p_flag_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_out == 4'b0000) || (flags_out == 4'b0100));

   p_read_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (mode_q == 8'h03 || mode_q == 8'h13)) |=> ($stable(acc_q) && flags_out == 4'b0000));

   p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !known) |=> ($stable(acc_q) && res_out == '0 && flags_out == 4'b0000));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(res_out) && $stable(flags_out)));

   p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_we && cmd_valid && mode_wdata != 8'h00) |=> $stable(acc_q));

endmodule

bind mac_copro mac_copro_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_we    (mode_we),
   .mode_wdata (mode_wdata),
   .cmd_valid  (cmd_valid),
   .op_dst     (op_dst),
   .op_src     (op_src),
   .res_out    (res_out),
   .flags_out  (flags_out),
   .mode_q     (mode_q),
   .acc_q      (acc_q)
);

// File: tb/tb_mac_copro.sv
`timescale 1ns/1ps
module tb_mac_copro;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_we = 1'b0;
   logic [7:0]  mode_wdata = '0;
   logic        cmd_valid = 1'b0;
   logic [15:0] op_dst = '0;
   logic [15:0] op_src = '0;
   logic [15:0] res_out;
   logic [3:0]  flags_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mac_copro dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_we    (mode_we),
      .mode_wdata (mode_wdata),
      .cmd_valid  (cmd_valid),
      .op_dst     (op_dst),
      .op_src     (op_src),
      .res_out    (res_out),
      .flags_out  (flags_out)
   );

   task automatic check(input string req, input logic [15:0] eo, input logic [3:0] ef);
      checks++;
      if (res_out !== eo || flags_out !== ef) begin
         errors++;
         $display("FAIL %s: res=%h flags=%b, expected res=%h flags=%b",
                  req, res_out, flags_out, eo, ef);
      end
   endtask

   task automatic set_mode(input logic [7:0] m);
      @(negedge clk);
      mode_we = 1'b1;
      mode_wdata = m;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic cmd(input logic [15:0] d, input logic [15:0] s);
      @(negedge clk);
      cmd_valid = 1'b1;
      op_dst = d;
      op_src = s;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic read_acc(input string req, input logic [31:0] exp_acc);
      set_mode(8'h13);
      cmd(16'h0, 16'h0);
      check(req, exp_acc[31:16], 4'b0000);
      set_mode(8'h03);
      cmd(16'h0, 16'h0);
      check(req, exp_acc[15:0], 4'b0000);
   endtask

   task automatic load_acc(input logic [31:0] v);
      set_mode(8'h02);
      cmd(v[31:16], v[15:0]);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 reset outputs", 16'h0000, 4'b0000);
      read_acc("R1 reset accumulator", 32'h0);
   endtask

   task automatic t_loads;
      load_acc(32'h12345678);
      check("R4 load full output", 16'h0000, 4'b0000);
      read_acc("R4 load full value", 32'h12345678);
      set_mode(8'h01);
      cmd(16'h9999, 16'hABCD);
      check("R3 load low output", 16'h0000, 4'b0000);
      read_acc("R3 load low value", 32'h0000ABCD);
   endtask

   task automatic t_clear;
      load_acc(32'hDEADBEEF);
      set_mode(8'h00);
      read_acc("R2 clear by mode write", 32'h0);
   endtask

   task automatic t_unsigned;
      load_acc(32'hFFFFFFFF);
      set_mode(8'h06);
      cmd(16'h0002, 16'h0003);
      check("R5 unsigned carry no flag", 16'h0005, 4'b0000);
      read_acc("R5 unsigned wrapped acc", 32'h00000005);
      set_mode(8'h00);
      set_mode(8'h16);
      cmd(16'hFFFF, 16'hFFFF);
      check("R7 unsigned high half", 16'hFFFE, 4'b0000);
      read_acc("R5 unsigned product", 32'hFFFE0001);
   endtask

   task automatic t_signed;
      set_mode(8'h00);
      set_mode(8'h07);
      cmd(16'hFFFE, 16'h0003);
      check("R6 signed negative product", 16'hFFFA, 4'b0000);
      cmd(16'h0004, 16'h0005);
      check("R6 signed accumulate", 16'h000E, 4'b0000);
      set_mode(8'h00);
      set_mode(8'h17);
      cmd(16'hFFFF, 16'hFFFF);
      check("R7 signed high half", 16'h0000, 4'b0000);
      read_acc("R6 signed product", 32'h00000001);
   endtask

   task automatic t_overflow;
      load_acc(32'h7FFFFFFF);
      set_mode(8'h17);
      cmd(16'h0001, 16'h0001);
      check("R6 positive overflow", 16'h8000, 4'b0100);
      repeat (3) @(negedge clk);
      check("R10 flags hold while idle", 16'h8000, 4'b0100);
      read_acc("R6 wrapped sum kept", 32'h80000000);
      load_acc(32'h80000000);
      set_mode(8'h07);
      cmd(16'hFFFF, 16'h0001);
      check("R6 negative overflow", 16'hFFFF, 4'b0100);
      read_acc("R6 negative wrap", 32'h7FFFFFFF);
   endtask

   task automatic t_unsupported;
      load_acc(32'h0BAD1234);
      set_mode(8'h13);
      cmd(16'h0, 16'h0);
      check("R8 read high before ignore", 16'h0BAD, 4'b0000);
      set_mode(8'h05);
      cmd(16'h1111, 16'h2222);
      check("R9 unsupported mode output", 16'h0000, 4'b0000);
      read_acc("R9 unsupported mode acc kept", 32'h0BAD1234);
      set_mode(8'h26);
      cmd(16'h1111, 16'h2222);
      check("R9 unsupported mode 0x26", 16'h0000, 4'b0000);
      read_acc("R9 acc kept after 0x26", 32'h0BAD1234);
      set_mode(8'h00);
      set_mode(8'h13);
      cmd(16'h0, 16'h0);
      set_mode(8'h06);
      cmd(16'h0003, 16'h0003);
      check("R9 setup nonzero", 16'h0009, 4'b0000);
      set_mode(8'h00);
      cmd(16'h4444, 16'h5555);
      check("R9 command in mode 0x00", 16'h0000, 4'b0000);
      read_acc("R9 mode 0x00 acc stays zero", 32'h0);
   endtask

   task automatic t_collision;
      load_acc(32'h00010002);
      set_mode(8'h06);
      cmd(16'h0002, 16'h0002);
      check("R10 result after one clock", 16'h0006, 4'b0000);
      @(negedge clk);
      mode_we = 1'b1;
      mode_wdata = 8'h13;
      cmd_valid = 1'b1;
      op_dst = 16'h00FF;
      op_src = 16'h00FF;
      @(negedge clk);
      mode_we = 1'b0;
      cmd_valid = 1'b0;
      check("R11 dropped command holds outputs", 16'h0006, 4'b0000);
      cmd(16'h0, 16'h0);
      check("R11 new mode active, acc unchanged", 16'h0001, 4'b0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_loads();
      t_clear();
      t_unsigned();
      t_signed();
      t_overflow();
      t_unsupported();
      t_collision();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule